// File: doc/BRIEF.md
# Collision Signal Presence Detector

This block watches a single digitised collision line from a transceiver and tells a media access controller whether a collision signal is present. A collision shows up on that line as a square wave of roughly 10 MHz. The detector samples the line on a fixed 250 MHz clock. It brings the line into its own clock domain and removes pulses that are too narrow to be real. It then measures the spacing between successive rising edges. The output goes high once two rising edges arrive with a spacing that fits a 10 MHz period.

Each rising edge that is correctly spaced restarts a hold timer, and the output stays high while that timer runs. When the square wave stops, the timer runs out and the output drops well inside a 350 ns bound. Edges that are spaced too far apart or too close together keep nothing alive. A loopback input shuts off the whole input path and forces the output low.

Top module: `col_presence_detect`

## Requirements
- R1: After reset, col_det is low, and it stays low while col_in is idle.
- R2: When col_in carries a square wave whose rising edges are PER_MIN (20) to PER_MAX (30) sample cycles apart, col_det rises at the second rising edge, exactly SYNC_STAGES + MIN_W + 1 (6) cycles after that edge is applied. In the cycle before, it is still low.
- R3: A single rising edge that has no qualifying edge before it never raises col_det.
- R4: While qualifying edges keep arriving, col_det stays high without a gap.
- R5: HOLD_CYC (62) cycles after the last qualifying rising edge loads the hold timer, col_det drops. Counted from the moment that edge is applied, this is 68 cycles, and col_det is still high at cycle 67.
- R6: A high pulse shorter than MIN_W (3) samples is treated as noise and never counts as an edge. A pulse of exactly MIN_W samples is accepted.
- R7: Two rising edges whose spacing is below PER_MIN or above PER_MAX are not qualifying. Spacings of exactly 20 and exactly 30 are qualifying.
- R8: While lbk_en is high, col_det is low in the same cycle, and progress toward detection is cleared. After lbk_en is released, a fresh burst again needs two qualifying edges.
- R9: Once col_in has been quiet for 87 sample cycles (350 ns), col_det is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 250 MHz sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lbk_en | input | 1 | Loopback: disables the collision path and forces col_det low |
| col_in | input | 1 | Digitised collision line, asynchronous to clk |
| col_det | output | 1 | High while a collision signal is present |

## Verification
A rising edge applied in cycle d reaches the hold timer after two synchroniser stages, three filter samples and one edge register. So the response to that edge appears at the sample taken in cycle d+6, and a release becomes visible in cycle d+68. The driver tasks work out these cycle numbers from the edge times they apply, then queue the expected level tagged with its cycle. The monitor compares only when its cycle counter reaches that tag, and it samples on the falling clock edge. Checks for noise pulses and for badly spaced edges expect a low level at each rising edge plus 8 and at two points after the burst. The check for the release bound falls 87 cycles after the last input transition.

// File: rtl/col_det_pkg.sv
package col_det_pkg;
  // Defaults for a 250 MHz sampling clock (4 ns per sample).
  localparam int DEF_SYNC_STAGES = 2;
  localparam int DEF_MIN_W       = 3;   // 12 ns minimum accepted pulse
  localparam int DEF_PER_MIN     = 20;  // 80 ns shortest accepted period
  localparam int DEF_PER_MAX     = 30;  // 120 ns longest accepted period
  localparam int DEF_HOLD_CYC    = 62;  // 248 ns release timer

  // Width of a counter that must be able to hold the value lim.
  function automatic int cnt_width(input int lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/col_sync.sv
module col_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sh_d = d;
    end else begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/col_glitch_filter.sv
module col_glitch_filter #(
  parameter int MIN_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic raw,
  output logic lvl
);
  import col_det_pkg::*;
  localparam int CW = cnt_width(MIN_W - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  // The level follows raw only after raw has differed for MIN_W samples.
  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (clr) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (raw == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(MIN_W - 1)) begin
      cnt_d = '0;
      lvl_d = raw;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl = lvl_q;

  // R6: a level change needs raw to agree with the new level over the last two samples
  assert_min_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_q != $past(lvl_q)) && !$past(clr)) |-> (($past(raw) == lvl_q) && ($past(raw, 2) == lvl_q)));
endmodule

// File: rtl/col_period_qual.sv
module col_period_qual #(
  parameter int PER_MIN = 20,
  parameter int PER_MAX = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic lvl,
  output logic valid_edge
);
  import col_det_pkg::*;
  localparam int GW  = cnt_width(PER_MAX + 1);
  localparam int SAT = PER_MAX + 1;

  logic          lvl_q;
  logic          armed_q, armed_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          rise, in_win;

  assign rise   = lvl & ~lvl_q;
  assign in_win = (gap_q >= GW'(PER_MIN)) && (gap_q <= GW'(PER_MAX));
  assign valid_edge = rise & armed_q & in_win & ~clr;

  always_comb begin
    armed_d = armed_q;
    gap_d   = gap_q;
    if (clr) begin
      armed_d = 1'b0;
      gap_d   = GW'(SAT);
    end else if (rise) begin
      armed_d = 1'b1;
      gap_d   = GW'(1);
    end else if (gap_q != GW'(SAT)) begin
      gap_d   = gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      armed_q <= 1'b0;
      gap_q   <= GW'(SAT);
    end else begin
      lvl_q   <= clr ? 1'b0 : lvl;
      armed_q <= armed_d;
      gap_q   <= gap_d;
    end
  end

  // Checker: cycles since the previous qualifying edge.
  localparam int SW = cnt_width(PER_MIN);
  logic [SW-1:0] since_q;
  logic          seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (valid_edge) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != SW'(PER_MIN)) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R7: qualifying edges are never closer than PER_MIN samples
  assert_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_edge && seen_q) |-> (since_q >= SW'(PER_MIN - 1)));
  // R2: a qualifying edge coincides with a rise of the filtered level
  assert_edge_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_edge |-> $rose(lvl));
endmodule

// File: rtl/col_release.sv
module col_release #(
  parameter int HOLD_CYC = 62
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  output logic active
);
  import col_det_pkg::*;
  localparam int RW = cnt_width(HOLD_CYC);

  logic [RW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (load)          cnt_d = RW'(HOLD_CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R4: a qualifying edge keeps the output active in the following cycle
  assert_load_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> active);
endmodule

// File: rtl/col_presence_detect.sv
module col_presence_detect
  import col_det_pkg::*;
#(
  parameter int SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int MIN_W       = DEF_MIN_W,
  parameter int PER_MIN     = DEF_PER_MIN,
  parameter int PER_MAX     = DEF_PER_MAX,
  parameter int HOLD_CYC    = DEF_HOLD_CYC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lbk_en,
  input  logic col_in,
  output logic col_det
);
  logic raw_s;
  logic filt_lvl;
  logic valid_edge;
  logic rel_active;

  col_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(col_in), .q(raw_s)
  );

  col_glitch_filter #(.MIN_W(MIN_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .clr(lbk_en), .raw(raw_s), .lvl(filt_lvl)
  );

  col_period_qual #(.PER_MIN(PER_MIN), .PER_MAX(PER_MAX)) u_qual (
    .clk(clk), .rst_n(rst_n), .clr(lbk_en), .lvl(filt_lvl), .valid_edge(valid_edge)
  );

  col_release #(.HOLD_CYC(HOLD_CYC)) u_rel (
    .clk(clk), .rst_n(rst_n), .clr(lbk_en), .load(valid_edge), .active(rel_active)
  );

  assign col_det = rel_active & ~lbk_en;

  // Checker: samples since the synchronised line last changed.
  localparam int REL_LIMIT = HOLD_CYC + MIN_W + 4;
  localparam int QW = cnt_width(REL_LIMIT + 1);
  logic          raw_q;
  logic [QW-1:0] quiet_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= 1'b0;
      quiet_q <= '0;
    end else begin
      raw_q <= raw_s;
      if (raw_s != raw_q)                 quiet_q <= '0;
      else if (quiet_q != QW'(REL_LIMIT + 1)) quiet_q <= quiet_q + 1'b1;
    end
  end

  // R9: a quiet line releases the output within the bound
  assert_release_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q > QW'(REL_LIMIT)) |-> !col_det);
  // R8: loopback empties the hold timer and blocks qualifying edges
  assert_lbk_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lbk_en |=> (!rel_active && !valid_edge));
endmodule

// File: tb/test_col_presence_detect.sv
`timescale 1ns/1ps
module test_col_presence_detect;
  logic clk = 1'b0;
  logic rst_n, lbk_en, col_in;
  logic col_det;

  always #2 clk = ~clk;  // 250 MHz

  col_presence_detect i_col_presence_detect (
    .clk(clk), .rst_n(rst_n), .lbk_en(lbk_en), .col_in(col_in), .col_det(col_det)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int unsigned cyc;
    logic        val;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  task automatic push(input int unsigned c, input logic v, input string t);
    exp_t e;
    e.cyc = c; e.val = v; e.tag = t;
    sbq.push_back(e);
  endtask

  // Monitor: pops expectations whose cycle has arrived.
  always @(negedge clk) begin
    if (rst_n) begin
      while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
        exp_t e;
        e = sbq.pop_front();
        n_cmp++;
        if (e.cyc < cyc) begin
          n_bad++;
          $display("FAIL %s: check for cycle %0d missed (actual cycle %0d, expected cycle %0d)",
                   e.tag, e.cyc, cyc, e.cyc);
        end else if (col_det !== e.val) begin
          n_bad++;
          $display("FAIL %s: col_det at cycle %0d actual %b expected %b", e.tag, cyc, col_det, e.val);
        end
      end
    end
  end

  // Driver: square wave of n rising edges, p cycles apart, high for h cycles.
  task automatic drive_wave(input int p, input int h, input int n, input bit on, input string tag);
    int unsigned d0, dl;
    @(negedge clk);
    d0 = cyc;
    dl = d0 + (n - 1) * p;
    if (on) begin
      push(d0 + p + 5, 1'b0, tag);   // R2: still low before the second edge arrives
      push(d0 + p + 6, 1'b1, tag);   // R2: high 6 cycles after the second edge
      push(dl + 6,     1'b1, "R4");
      push(dl + 67,    1'b1, "R5");
      push(dl + 68,    1'b0, "R5");
      push(dl + h + 87, 1'b0, "R9");
    end else begin
      for (int i = 1; i < n; i++) push(d0 + i * p + 8, 1'b0, tag);
      push(dl + 40, 1'b0, tag);
      push(dl + 70, 1'b0, tag);
    end
    for (int i = 0; i < n; i++) begin
      col_in = 1'b1;
      repeat (h) @(negedge clk);
      col_in = 1'b0;
      repeat (p - h) @(negedge clk);
    end
    repeat (100) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual run still busy, expected finished (queue %0d)", sbq.size());
      finish_run();
    end
  end

  initial begin
    int unsigned d0;
    rst_n = 1'b0; lbk_en = 1'b0; col_in = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    push(cyc + 1, 1'b0, "R1");
    push(cyc + 15, 1'b0, "R1");
    repeat (20) @(negedge clk);

    drive_wave(25, 12, 8, 1'b1, "R2");   // nominal 10 MHz
    drive_wave(20, 10, 6, 1'b1, "R7");   // spacing exactly PER_MIN accepted
    drive_wave(30, 15, 6, 1'b1, "R7");   // spacing exactly PER_MAX accepted
    drive_wave(31, 15, 6, 1'b0, "R7");   // just too wide
    drive_wave(19,  9, 6, 1'b0, "R7");   // just too narrow
    drive_wave(40, 20, 5, 1'b0, "R7");   // far too wide
    drive_wave(25, 12, 1, 1'b0, "R3");   // lone edge
    drive_wave(25,  2, 6, 1'b0, "R6");   // pulses below MIN_W
    drive_wave(25,  3, 6, 1'b1, "R6");   // pulses of exactly MIN_W

    // R8: loopback in the middle of a burst
    @(negedge clk);
    d0 = cyc;
    push(d0 + 31,  1'b1, "R2");
    push(d0 + 74,  1'b1, "R4");
    push(d0 + 76,  1'b0, "R8");
    push(d0 + 100, 1'b0, "R8");
    push(d0 + 149, 1'b0, "R8");
    push(d0 + 170, 1'b0, "R8");
    for (int i = 0; i < 6; i++) begin
      if (i == 3) lbk_en = 1'b1;
      col_in = 1'b1;
      repeat (12) @(negedge clk);
      col_in = 1'b0;
      repeat (13) @(negedge clk);
    end
    lbk_en = 1'b0;
    repeat (60) @(negedge clk);
    drive_wave(25, 12, 4, 1'b1, "R8");   // fresh burst after loopback

    wait (sbq.size() == 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule